// File: doc/BRIEF.md
# Serial Program Bootloader Sequencer

This block drives a boot-time program load from a serial byte stream. Bytes arrive one per cycle on a receive-byte interface, for example from a UART receiver, and every accepted byte is returned on a transmit-byte interface one cycle later so that the host can watch the echo. Three bytes form one 24-bit word, least significant byte first. The first word gives the program length in words. The second gives the load and entry address. Each word after that is written into instruction memory through a one-cycle write strobe, at the entry address plus a running offset.

Once the last word is written, the block pulses a clear for the operating-mode register and a clear for the condition-code register in the same cycle. In the next cycle it raises a start pulse that carries the entry address. From then on it is idle and ignores the receive interface until the next reset. The sequence runs through these states: `ST_SIZE` (collect the length word) goes to `ST_ADDR` when a word completes. `ST_ADDR` (collect the address word) goes to `ST_LOAD` when a word completes and the length is non-zero, or straight to `ST_CLEAR` when the length is zero. `ST_LOAD` (write program words) goes to `ST_CLEAR` when the final word completes. `ST_CLEAR` (one cycle, both clears) always goes to `ST_LAUNCH` (one cycle, start pulse), which always goes to `ST_DONE` (idle until reset).

Top module: `boot_loader_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, `busy` is 1 and `tx_valid`, `mem_we`, `mode_clr`, `ccr_clr` and `start_pulse` are all 0.
- R2: Each byte accepted in `ST_SIZE`, `ST_ADDR` or `ST_LOAD` appears on `tx_byte` with `tx_valid` high exactly one cycle after the cycle in which `rx_valid` carried it.
- R3: The first three accepted bytes form the program length in words. The first byte is bits 7:0, the second is bits 15:8 and the third is bits 23:16.
- R4: The next three accepted bytes form the entry address in the same byte order. `start_addr` carries this address when `start_pulse` is high.
- R5: Each later group of three bytes forms one program word in the same byte order. The word appears on `mem_wdata` with `mem_we` high for one cycle, in the cycle after its third byte.
- R6: Program word k (counting from 0) is written at entry address plus k, modulo 2^24. Exactly as many writes occur as the length word gives.
- R7: After the last write, `mode_clr` and `ccr_clr` are high together for one cycle. `start_pulse` is high for exactly the following cycle.
- R8: A length of zero causes no memory write. The clears follow directly after the address word is complete.
- R9: `busy` stays 1 up to and including the start-pulse cycle and is 0 afterwards. After hand-off, received bytes cause no echo, no write and no further start pulse until reset.
- R10: Idle cycles between bytes of any length do not change the words formed. Each cycle with `rx_valid` high counts as one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | Echo byte present this cycle |
| tx_byte | output | 8 | Echoed byte |
| mem_we | output | 1 | One-cycle instruction-memory write strobe |
| mem_addr | output | 24 | Write address |
| mem_wdata | output | 24 | Program word to write |
| mode_clr | output | 1 | Clear pulse for the operating-mode register |
| ccr_clr | output | 1 | Clear pulse for the condition-code register |
| start_pulse | output | 1 | One-cycle hand-off to the processor |
| start_addr | output | 24 | Entry address, valid with `start_pulse` |
| busy | output | 1 | Load still in progress |

## Verification
Some properties are checked on every cycle. Each echo must match the byte seen one cycle earlier. A write must never fall outside the busy period or coincide with a clear. The start pulse must follow the clears by exactly one cycle, and `busy` must drop right after it. Once idle, the block must stay silent. Only the bench scenarios can show that length and address bytes are assembled in the right order, that addresses advance and wrap correctly, that the write count matches the length, and that a zero length skips the load. These results depend on whole byte sequences rather than on neighbouring cycles.

// File: rtl/bl_pkg.sv
package bl_pkg;

    localparam int BL_BYTE_W     = 8;
    localparam int BL_WORD_BYTES = 3;
    localparam int BL_WORD_W     = BL_BYTE_W * BL_WORD_BYTES;

    typedef enum logic [2:0] {
        ST_SIZE   = 3'd0,
        ST_ADDR   = 3'd1,
        ST_LOAD   = 3'd2,
        ST_CLEAR  = 3'd3,
        ST_LAUNCH = 3'd4,
        ST_DONE   = 3'd5
    } boot_state_t;

endpackage

// File: rtl/bl_byte_packer.sv
module bl_byte_packer #(
    parameter int BYTE_W     = 8,
    parameter int WORD_BYTES = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           byte_en,
    input  logic [BYTE_W-1:0]              byte_in,
    output logic                           word_valid,
    output logic [BYTE_W*WORD_BYTES-1:0]   word_out
);
    localparam int WORD_W = BYTE_W * WORD_BYTES;
    localparam int IDX_W  = (WORD_BYTES > 2) ? $clog2(WORD_BYTES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_BYTES - 1);

    logic [IDX_W-1:0]  idx_q;
    logic [WORD_W-1:0] acc_q;

    // Bytes land least significant first; the final byte completes the word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q      <= '0;
            acc_q      <= '0;
            word_valid <= 1'b0;
            word_out   <= '0;
        end else begin
            word_valid <= 1'b0;
            if (byte_en) begin
                if (idx_q == LAST_IDX) begin
                    word_out   <= {byte_in, acc_q[WORD_W-BYTE_W-1:0]};
                    word_valid <= 1'b1;
                    idx_q      <= '0;
                end else begin
                    acc_q[idx_q*BYTE_W +: BYTE_W] <= byte_in;
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/bl_echo.sv
module bl_echo #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_byte
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_byte  <= '0;
        end else begin
            tx_valid <= en;
            if (en) begin
                tx_byte <= byte_in;
            end
        end
    end

endmodule

// File: rtl/bl_seq_fsm.sv
module bl_seq_fsm
    import bl_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_in,
    output logic              accepting,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mode_clr,
    output logic              ccr_clr,
    output logic              start_pulse,
    output logic [WORD_W-1:0] start_addr,
    output logic              busy
);
    boot_state_t       state_q, state_d;
    logic [WORD_W-1:0] size_q;
    logic [WORD_W-1:0] base_q;
    logic [WORD_W-1:0] offset_q;
    logic              last_word;

    assign last_word = (offset_q + 1'b1) == size_q;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SIZE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SIZE:   if (word_valid) state_d = ST_ADDR;
            ST_ADDR:   if (word_valid) state_d = (size_q == '0) ? ST_CLEAR : ST_LOAD;
            ST_LOAD:   if (word_valid && last_word) state_d = ST_CLEAR;
            ST_CLEAR:  state_d = ST_LAUNCH;
            ST_LAUNCH: state_d = ST_DONE;
            ST_DONE:   state_d = ST_DONE;
        endcase
    end

    // Header and offset registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q   <= '0;
            base_q   <= '0;
            offset_q <= '0;
        end else if (word_valid) begin
            unique case (state_q)
                ST_SIZE: size_q <= word_in;
                ST_ADDR: begin
                    base_q   <= word_in;
                    offset_q <= '0;
                end
                ST_LOAD: offset_q <= offset_q + 1'b1;
                default: ;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        accepting   = 1'b0;
        mem_we      = 1'b0;
        mode_clr    = 1'b0;
        ccr_clr     = 1'b0;
        start_pulse = 1'b0;
        busy        = 1'b1;
        unique case (state_q)
            ST_SIZE, ST_ADDR: accepting = 1'b1;
            ST_LOAD: begin
                accepting = 1'b1;
                mem_we    = word_valid;
            end
            ST_CLEAR: begin
                mode_clr = 1'b1;
                ccr_clr  = 1'b1;
            end
            ST_LAUNCH: start_pulse = 1'b1;
            ST_DONE:   busy = 1'b0;
        endcase
    end

    assign mem_addr   = base_q + offset_q;
    assign mem_wdata  = word_in;
    assign start_addr = base_q;

endmodule

// File: rtl/boot_loader_seq.sv
module boot_loader_seq
    import bl_pkg::*;
#(
    parameter int BYTE_W     = BL_BYTE_W,
    parameter int WORD_BYTES = BL_WORD_BYTES
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rx_valid,
    input  logic [BYTE_W-1:0]            rx_byte,
    output logic                         tx_valid,
    output logic [BYTE_W-1:0]            tx_byte,
    output logic                         mem_we,
    output logic [BYTE_W*WORD_BYTES-1:0] mem_addr,
    output logic [BYTE_W*WORD_BYTES-1:0] mem_wdata,
    output logic                         mode_clr,
    output logic                         ccr_clr,
    output logic                         start_pulse,
    output logic [BYTE_W*WORD_BYTES-1:0] start_addr,
    output logic                         busy
);
    localparam int WORD_W = BYTE_W * WORD_BYTES;

    logic              accepting;
    logic              take_byte;
    logic              word_valid;
    logic [WORD_W-1:0] word;

    assign take_byte = rx_valid && accepting;

    bl_echo #(.BYTE_W(BYTE_W)) u_echo (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (take_byte),
        .byte_in  (rx_byte),
        .tx_valid (tx_valid),
        .tx_byte  (tx_byte)
    );

    bl_byte_packer #(.BYTE_W(BYTE_W), .WORD_BYTES(WORD_BYTES)) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_en    (take_byte),
        .byte_in    (rx_byte),
        .word_valid (word_valid),
        .word_out   (word)
    );

    bl_seq_fsm #(.WORD_W(WORD_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_valid  (word_valid),
        .word_in     (word),
        .accepting   (accepting),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mode_clr    (mode_clr),
        .ccr_clr     (ccr_clr),
        .start_pulse (start_pulse),
        .start_addr  (start_addr),
        .busy        (busy)
    );

endmodule

// File: rtl/bl_checker.sv
module bl_checker #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic [BYTE_W-1:0] rx_byte,
    input logic              tx_valid,
    input logic [BYTE_W-1:0] tx_byte,
    input logic              mem_we,
    input logic              mode_clr,
    input logic              ccr_clr,
    input logic              start_pulse,
    input logic              busy
);
    p_echo_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> ($past(rx_valid) && tx_byte == $past(rx_byte)));

    p_write_in_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (busy && !mode_clr && !start_pulse));

    p_clear_then_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_clr |=> start_pulse);

    p_start_after_ccr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> $past(ccr_clr));

    p_idle_after_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !busy);

    p_silent_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> (!tx_valid && !mem_we && !start_pulse && !mode_clr));

endmodule

bind boot_loader_seq bl_checker #(.BYTE_W(BYTE_W)) u_bl_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_valid    (rx_valid),
    .rx_byte     (rx_byte),
    .tx_valid    (tx_valid),
    .tx_byte     (tx_byte),
    .mem_we      (mem_we),
    .mode_clr    (mode_clr),
    .ccr_clr     (ccr_clr),
    .start_pulse (start_pulse),
    .busy        (busy)
);

// File: tb/boot_loader_seq_test.sv
module boot_loader_seq_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rx_valid;
    logic [7:0]  rx_byte;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic        mem_we;
    logic [23:0] mem_addr;
    logic [23:0] mem_wdata;
    logic        mode_clr;
    logic        ccr_clr;
    logic        start_pulse;
    logic [23:0] start_addr;
    logic        busy;

    always #5 clk = ~clk;

    boot_loader_seq uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mode_clr(mode_clr),
        .ccr_clr(ccr_clr), .start_pulse(start_pulse), .start_addr(start_addr),
        .busy(busy)
    );

    int checks = 0, fails = 0;
    int cyc = 0, last_clear = -10, last_wr = -10;
    int starts = 0, echoes = 0, writes = 0;
    logic [23:0] exp_start;
    logic [7:0]  echo_q[$];
    logic [47:0] wr_q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Monitor: pops expectations as the design produces results.
    always @(negedge clk) begin
        logic [7:0]  e;
        logic [47:0] w;
        if (rst_n) begin
            cyc++;
            if (tx_valid) begin
                echoes++;
                if (echo_q.size() == 0) check(1'b0, "R9", "unexpected echo", 48'(tx_byte), 48'h0);
                else begin
                    e = echo_q.pop_front();
                    check(tx_byte == e, "R2", "echo byte", 48'(tx_byte), 48'(e));
                end
            end
            if (mem_we) begin
                writes++;
                last_wr = cyc;
                if (wr_q.size() == 0) check(1'b0, "R6", "unexpected write", {mem_addr, mem_wdata}, 48'h0);
                else begin
                    w = wr_q.pop_front();
                    check({mem_addr, mem_wdata} == w, "R5", "write addr/data", {mem_addr, mem_wdata}, w);
                end
            end
            if (mode_clr) begin
                last_clear = cyc;
                check(ccr_clr, "R7", "ccr clear with mode clear", 48'(ccr_clr), 48'h1);
                check(cyc > last_wr, "R7", "clear after last write", 48'(cyc), 48'(last_wr));
            end
            if (start_pulse) begin
                starts++;
                check(last_clear == cyc - 1, "R7", "start one cycle after clear", 48'(last_clear), 48'(cyc - 1));
                check(start_addr == exp_start, "R4", "start address", 48'(start_addr), 48'(exp_start));
                check(busy, "R9", "busy during start", 48'(busy), 48'h1);
            end
        end
    end

    task automatic send_byte(input logic [7:0] b, input int gap, input bit echo_exp);
        rx_valid = 1'b1;
        rx_byte  = b;
        if (echo_exp) echo_q.push_back(b);
        @(negedge clk);
        rx_valid = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    // R3/R4/R5 byte order: bits 7:0 first, then 15:8, then 23:16.
    task automatic send_word(input logic [23:0] w, input int gap);
        send_byte(w[7:0], gap, 1'b1);
        send_byte(w[15:8], gap, 1'b1);
        send_byte(w[23:16], gap, 1'b1);
    endtask

    function automatic logic [23:0] pat(input int i, input logic [23:0] seed);
        return seed ^ (24'(i) * 24'h0A0B0D) ^ 24'(i);
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        rx_valid = 1'b0;
        rx_byte = 8'h00;
        echo_q.delete();
        wr_q.delete();
        repeat (3) @(negedge clk);
        starts = 0;
        last_clear = -10;
        last_wr = -10;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_load(input int size, input logic [23:0] addr, input int gap,
                            input logic [23:0] seed);
        int n = 0;
        int s0 = starts;
        exp_start = addr;
        for (int i = 0; i < size; i++) wr_q.push_back({addr + 24'(i), pat(i, seed)});
        send_word(24'(size), gap);
        send_word(addr, gap);
        for (int i = 0; i < size; i++) send_word(pat(i, seed), gap);
        while (starts == s0 && n < 200) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
        check(starts == s0 + 1, "R7", "one start pulse", 48'(starts), 48'(s0 + 1));
        check(wr_q.size() == 0, "R3", "all expected writes seen", 48'(wr_q.size()), 48'h0);
        check(echo_q.size() == 0, "R2", "all echoes seen", 48'(echo_q.size()), 48'h0);
        check(!busy, "R9", "busy low after hand-off", 48'(busy), 48'h0);
    endtask

    initial begin
        int w0, e0;
        rst_n = 1'b0;
        rx_valid = 1'b0;
        rx_byte = 8'h00;
        repeat (3) @(negedge clk);
        // R1 during reset
        check(busy && !tx_valid && !mem_we && !mode_clr && !ccr_clr && !start_pulse,
              "R1", "outputs in reset", {42'h0, busy, tx_valid, mem_we, mode_clr, ccr_clr, start_pulse},
              48'h20);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy && !tx_valid && !mem_we && !start_pulse, "R1", "outputs after reset",
              {44'h0, busy, tx_valid, mem_we, start_pulse}, 48'h8);

        // Back-to-back bytes, three words: R3 R4 R5 R6 R7
        w0 = writes;
        run_load(3, 24'h000100, 0, 24'h123456);
        check(writes - w0 == 3, "R6", "write count", 48'(writes - w0), 48'h3);

        // R9: bytes after hand-off ignored
        e0 = echoes;
        w0 = writes;
        for (int i = 0; i < 6; i++) send_byte(8'(8'hA0 + i), 1, 1'b0);
        repeat (5) @(negedge clk);
        check(echoes == e0, "R9", "no echo after hand-off", 48'(echoes), 48'(e0));
        check(writes == w0, "R9", "no write after hand-off", 48'(writes), 48'(w0));
        check(starts == 1, "R9", "no second start", 48'(starts), 48'h1);

        // R8: zero length
        do_reset();
        w0 = writes;
        run_load(0, 24'h00C0DE, 2, 24'h0);
        check(writes == w0, "R8", "no write for zero length", 48'(writes), 48'(w0));

        // R10 with gaps, R6 address wrap past 24'hFFFFFF
        do_reset();
        w0 = writes;
        run_load(4, 24'hFFFFFE, 3, 24'hABCDEF);
        check(writes - w0 == 4, "R10", "write count with gaps", 48'(writes - w0), 48'h4);

        // Single word with an uneven gap
        do_reset();
        run_load(1, 24'h3C5A96, 1, 24'h00FF01);

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule